// File: doc/BRIEF.md
# Chained SPI Register Node

This block is the serial front end of one device in a string of identical devices that share a single SPI host. Chip select, serial clock and the host's data line pass straight through to the next device. Read data and interrupts from further down the string are merged in on the way back. Each device holds a small byte-wide register file: a fixed identity byte, a configuration byte giving thread and core counts, a node-address byte, a one-bit control register, and a few scratch bytes.

Every device starts without an address. An enable token enters at the head of the string. Only the device that holds the token and has no address yet answers device address 0. The host uses that address to give it a number. The host then sets the control bit, which hands the token to the next device, and repeats until an identity read comes back wrong. A reserved device address reaches every node with a single write.

The serial lines are brought into the system clock domain through flop synchronisers. Rising edges of the serial clock are detected in that domain.

Top module: `spi_chain_node`

## Requirements
- R1: Transfers use SPI mode 0, most significant bit first, framed by an active-low chip select. csn_o, sclk_o and mosi_o follow csn_i, sclk_i and mosi_i unchanged.
- R2: In header byte 0, bit 7 = 1 selects a read and bit 7 = 0 selects a write. Bits 6:0 of byte 0 hold the device address. Header byte 1 is the register address. Only the addressed node acts on the transfer.
- R3: A read returns one dummy byte after the header, taken from miso_dn_i. The register data follows from the next byte on.
- R4: A write takes its data bytes directly after the header.
- R5: During a multi-byte read or write, the register address increases by one after each data byte.
- R6: Register 0x00 reads ID_VALUE (default 0x6B). Register 0x01 reads {MACROS, THREADS}, with the core count in bits 7:4 and the thread count in bits 3:0 (default 0x34). Writes to either register have no effect.
- R7: A node with node address 0 answers device address 0 only while id_en_i is high. A write to register 0x02 sets its node address from bits 6:0. After that the node answers that address and no longer answers 0.
- R8: Bit 0 of register 0x03 drives id_en_o, which is the token for the next node. It reads back as 0x01 or 0x00 and resets to 0.
- R9: A write to device address 0x7F is accepted by every node. A read from 0x7F drives no data from any node.
- R10: Unless a node is in the data phase of a read addressed to it, miso_o equals miso_dn_i. A read of an absent device therefore returns the downstream level.
- R11: irq_o is the OR of irq_local_i and irq_dn_i.
- R12: Raising chip select discards any partial byte and resets the byte position. A cut-short data byte writes nothing, and the next transfer starts again with a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn_i | input | 1 | Chip select from the host or the previous node |
| sclk_i | input | 1 | Serial clock in |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data towards the host |
| csn_o | output | 1 | Chip select to the next node |
| sclk_o | output | 1 | Serial clock to the next node |
| mosi_o | output | 1 | Serial data to the next node |
| miso_dn_i | input | 1 | Serial return data from the next node |
| irq_local_i | input | 1 | Interrupt raised by this device |
| irq_dn_i | input | 1 | Interrupt from the next node |
| irq_o | output | 1 | Merged interrupt towards the host |
| id_en_i | input | 1 | Enumeration token from the previous node |
| id_en_o | output | 1 | Enumeration token to the next node |

## Verification
The hardest state to reach is the second node of a string answering address 0. That only happens after the first node has been given an address and has released its token through its own control register. The bench therefore chains two instances and enumerates them the way a host would. It checks at every step which node, if any, answers address 0. Abort handling is reached by raising chip select part way through a header byte and part way through a data byte, then reading the target register back.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  // register offsets; the enumeration flow depends on them
  localparam logic [7:0] REG_IDENT = 8'h00;
  localparam logic [7:0] REG_INFO  = 8'h01;
  localparam logic [7:0] REG_NODE  = 8'h02;
  localparam logic [7:0] REG_CTRL  = 8'h03;
  localparam logic [7:0] REG_SCR0  = 8'h04;

  // does a header device field select this node
  function automatic logic dev_hit(input logic [6:0] dev, input logic [6:0] mine,
                                   input logic [6:0] bcast, input logic token);
    if (dev == bcast) return 1'b1;
    if (mine == 7'd0) return token && (dev == 7'd0);
    return dev == mine;
  endfunction

  function automatic logic [7:0] info_byte(input logic [3:0] cores, input logic [3:0] threads);
    return {cores, threads};
  endfunction
endpackage

// File: rtl/spi_chain_sync.sv
module spi_chain_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_chain_frame.sv
module spi_chain_frame (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_act,
  input  logic       sclk_s,
  input  logic       mosi_s,
  input  logic [7:0] load_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic [1:0] byte_idx,
  output logic       tx_bit
);
  logic       sclk_q;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic [1:0] idx_q;
  logic       rise;

  assign rise      = cs_act & sclk_s & ~sclk_q;
  assign byte_done = rise & (bit_cnt == 3'd7);
  assign rx_byte   = {rx_sh, mosi_s};
  assign byte_idx  = idx_q;
  assign tx_bit    = tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      idx_q   <= '0;
    end else begin
      sclk_q <= sclk_s;
      if (!cs_act) begin
        bit_cnt <= '0;
        idx_q   <= '0;
        tx_sh   <= '0;
      end else if (rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        rx_sh   <= {rx_sh[5:0], mosi_s};
        if (bit_cnt == 3'd7) begin
          tx_sh <= load_byte;
          if (idx_q != 2'd3) idx_q <= idx_q + 2'd1;
        end else begin
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_chain_regs.sv
module spi_chain_regs
  import spi_chain_pkg::*;
#(
  parameter logic [7:0] ID_VALUE = 8'h6B,
  parameter logic [3:0] MACROS   = 4'd3,
  parameter logic [3:0] THREADS  = 4'd4,
  parameter int         N_SCR    = 4,
  parameter logic [6:0] BCAST    = 7'h7F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_act,
  input  logic       byte_done,
  input  logic [7:0] rx_byte,
  input  logic [1:0] byte_idx,
  input  logic       token_in,
  output logic [7:0] load_byte,
  output logic       drive,
  output logic       wr_stb,
  output logic       hdr_rd,
  output logic       hdr_bcast,
  output logic [6:0] node_addr,
  output logic       token_out
);
  localparam logic [7:0] INFO = info_byte(MACROS, THREADS);

  logic [6:0] hdr_dev;
  logic       hit;
  logic [7:0] cur_addr;
  logic       ctrl_q;
  logic [7:0] scr [N_SCR];
  logic [7:0] rd_mux;

  assign hdr_bcast = (hdr_dev == BCAST);
  assign wr_stb    = byte_done && (byte_idx >= 2'd2) && !hdr_rd && hit;
  assign drive     = cs_act && hdr_rd && hit && !hdr_bcast && (byte_idx == 2'd3);
  assign token_out = ctrl_q;

  always_comb begin
    rd_mux = 8'h00;
    if (cur_addr == REG_IDENT) rd_mux = ID_VALUE;
    if (cur_addr == REG_INFO)  rd_mux = INFO;
    if (cur_addr == REG_NODE)  rd_mux = {1'b0, node_addr};
    if (cur_addr == REG_CTRL)  rd_mux = {7'd0, ctrl_q};
    for (int i = 0; i < N_SCR; i++)
      if (cur_addr == REG_SCR0 + 8'(i)) rd_mux = scr[i];
  end

  assign load_byte = (hdr_rd && hit && !hdr_bcast && byte_idx >= 2'd2) ? rd_mux : 8'h00;

  // header and address counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_rd   <= 1'b0;
      hdr_dev  <= '0;
      hit      <= 1'b0;
      cur_addr <= '0;
    end else if (!cs_act) begin
      hit      <= 1'b0;
      cur_addr <= '0;
    end else if (byte_done) begin
      case (byte_idx)
        2'd0: begin
          hdr_rd  <= rx_byte[7];
          hdr_dev <= rx_byte[6:0];
        end
        2'd1: begin
          cur_addr <= rx_byte;
          hit      <= dev_hit(hdr_dev, node_addr, BCAST, token_in);
        end
        default: cur_addr <= cur_addr + 8'd1;
      endcase
    end
  end

  // fixed control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_addr <= '0;
      ctrl_q    <= 1'b0;
    end else if (wr_stb) begin
      if (cur_addr == REG_NODE) node_addr <= rx_byte[6:0];
      if (cur_addr == REG_CTRL) ctrl_q    <= rx_byte[0];
    end
  end

  // scratch bytes
  for (genvar g = 0; g < N_SCR; g++) begin : g_scr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scr[g] <= 8'h00;
      else if (wr_stb && cur_addr == REG_SCR0 + 8'(g)) scr[g] <= rx_byte;
    end
  end
endmodule

// File: rtl/spi_chain_node.sv
module spi_chain_node #(
  parameter logic [7:0] ID_VALUE    = 8'h6B,
  parameter logic [3:0] MACROS      = 4'd3,
  parameter logic [3:0] THREADS     = 4'd4,
  parameter int         N_SCR       = 4,
  parameter logic [6:0] BCAST       = 7'h7F,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csn_i,
  input  logic sclk_i,
  input  logic mosi_i,
  output logic miso_o,
  output logic csn_o,
  output logic sclk_o,
  output logic mosi_o,
  input  logic miso_dn_i,
  input  logic irq_local_i,
  input  logic irq_dn_i,
  output logic irq_o,
  input  logic id_en_i,
  output logic id_en_o
);
  logic [2:0] pins_s;
  logic       cs_act;
  logic       byte_done;
  logic [7:0] rx_byte;
  logic [1:0] byte_idx;
  logic       tx_bit;
  logic [7:0] load_byte;
  logic       drive;
  logic       wr_stb;
  logic       hdr_rd;
  logic       hdr_bcast;
  logic [6:0] node_addr;

  assign csn_o  = csn_i;
  assign sclk_o = sclk_i;
  assign mosi_o = mosi_i;
  assign irq_o  = irq_local_i | irq_dn_i;

  spi_chain_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({csn_i, sclk_i, mosi_i}), .q(pins_s)
  );

  assign cs_act = ~pins_s[2];

  spi_chain_frame u_frame (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_s(pins_s[1]), .mosi_s(pins_s[0]),
    .load_byte(load_byte), .byte_done(byte_done), .rx_byte(rx_byte),
    .byte_idx(byte_idx), .tx_bit(tx_bit)
  );

  spi_chain_regs #(
    .ID_VALUE(ID_VALUE), .MACROS(MACROS), .THREADS(THREADS), .N_SCR(N_SCR), .BCAST(BCAST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .byte_done(byte_done), .rx_byte(rx_byte),
    .byte_idx(byte_idx), .token_in(id_en_i), .load_byte(load_byte), .drive(drive),
    .wr_stb(wr_stb), .hdr_rd(hdr_rd), .hdr_bcast(hdr_bcast), .node_addr(node_addr),
    .token_out(id_en_o)
  );

  assign miso_o = drive ? tx_bit : miso_dn_i;
endmodule

// File: rtl/spi_chain_node_chk.sv
module spi_chain_node_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_act,
  input logic       miso_o,
  input logic       miso_dn_i,
  input logic       irq_dn_i,
  input logic       irq_local_i,
  input logic       irq_o,
  input logic       drive,
  input logic       hdr_rd,
  input logic       hdr_bcast,
  input logic       wr_stb,
  input logic [6:0] node_addr,
  input logic       id_en_o
);
  // R10: an idle frame never overrides the downstream line
  p_idle_fwd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> (miso_o == miso_dn_i));

  // R3: data is driven only for a read
  p_drive_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> hdr_rd);

  // R9: a broadcast read stays silent
  p_bcast_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> !hdr_bcast);

  // R7: node address only moves after an accepted write byte
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(node_addr));

  // R8: token output only moves after an accepted write byte
  p_token_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(id_en_o));

  // R11: either interrupt source raises the merged line
  p_irq_merge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_dn_i || irq_local_i) |-> irq_o);
endmodule

bind spi_chain_node spi_chain_node_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .miso_o(miso_o), .miso_dn_i(miso_dn_i),
  .irq_dn_i(irq_dn_i), .irq_local_i(irq_local_i), .irq_o(irq_o), .drive(drive),
  .hdr_rd(hdr_rd), .hdr_bcast(hdr_bcast), .wr_stb(wr_stb), .node_addr(node_addr),
  .id_en_o(id_en_o)
);

// File: tb/test_spi_chain_node.sv
module test_spi_chain_node;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam logic [7:0] ID_EXP = 8'h6B;
  localparam logic [7:0] INFO_EXP = 8'h34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic dn_miso = 1'b0;
  logic irq0 = 1'b0, irq1 = 1'b0, irq_end = 1'b0;

  logic miso_top, csn01, sclk01, mosi01, miso10, irq10, irq_top, tok01, tok_end;
  logic csn_end, sclk_end, mosi_end;

  int n_checks = 0, n_fail = 0;
  logic [7:0] rbuf [4];
  logic [7:0] wbuf [4];
  logic [7:0] dummy_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_chain_node i_spi_chain_node (
    .clk(clk), .rst_n(rst_n), .csn_i(csn), .sclk_i(sclk), .mosi_i(mosi), .miso_o(miso_top),
    .csn_o(csn01), .sclk_o(sclk01), .mosi_o(mosi01), .miso_dn_i(miso10),
    .irq_local_i(irq0), .irq_dn_i(irq10), .irq_o(irq_top), .id_en_i(1'b1), .id_en_o(tok01)
  );

  spi_chain_node i_spi_chain_node_dn (
    .clk(clk), .rst_n(rst_n), .csn_i(csn01), .sclk_i(sclk01), .mosi_i(mosi01), .miso_o(miso10),
    .csn_o(csn_end), .sclk_o(sclk_end), .mosi_o(mosi_end), .miso_dn_i(dn_miso),
    .irq_local_i(irq1), .irq_dn_i(irq_end), .irq_o(irq10), .id_en_i(tok01), .id_en_o(tok_end)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      wait_clk(HALF);
      rx[b] = miso_top;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic pbits(input logic [7:0] tx, input int nb);
    for (int b = 7; b > 7 - nb; b--) begin
      mosi = tx[b];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic rd, input logic [6:0] dev, input logic [7:0] ra, input int n);
    logic [7:0] r;
    csn = 1'b0;
    wait_clk(HALF);
    xbyte({rd, dev}, r);
    xbyte(ra, r);
    if (rd) xbyte(8'hFF, dummy_q);
    for (int i = 0; i < n; i++) begin
      xbyte(rd ? 8'hFF : wbuf[i], r);
      rbuf[i] = r;
    end
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic rd1(input logic [6:0] dev, input logic [7:0] ra, output logic [7:0] v);
    xfer(1'b1, dev, ra, 1);
    v = rbuf[0];
  endtask

  task automatic wr1(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] v);
    wbuf[0] = v;
    xfer(1'b0, dev, ra, 1);
  endtask

  task automatic t_reset;
    check("R10 idle miso", {7'd0, miso_top}, 8'h00);
    check("R8 token reset", {7'd0, tok01}, 8'h00);
    check("R11 irq reset", {7'd0, irq_top}, 8'h00);
  endtask

  task automatic t_passthru;
    csn = 1'b0; mosi = 1'b1; wait_clk(HALF);
    sclk = 1'b1; wait_clk(2);
    check("R1 pass lines", {5'd0, csn_end, sclk_end, mosi_end}, 8'h03);
    sclk = 1'b0; mosi = 1'b0; wait_clk(HALF);
    csn = 1'b1; wait_clk(2);
    check("R1 pass csn", {7'd0, csn_end}, 8'h01);
    wait_clk(4 * HALF);
  endtask

  task automatic t_enumerate;
    logic [7:0] v;
    rd1(7'd0, 8'h00, v);
    check("R6 R1 ident msb first", v, ID_EXP);
    check("R3 dummy from downstream", dummy_q, 8'h00);
    wr1(7'd0, 8'h02, 8'h01);
    rd1(7'd1, 8'h00, v);
    check("R7 answers new addr", v, ID_EXP);
    rd1(7'd0, 8'h00, v);
    check("R7 R8 nobody at zero", v, 8'h00);
    wr1(7'd1, 8'h03, 8'h01);
    check("R8 token out", {7'd0, tok01}, 8'h01);
    rd1(7'd0, 8'h00, v);
    check("R8 next node at zero", v, ID_EXP);
    wr1(7'd0, 8'h02, 8'h02);
    rd1(7'd2, 8'h00, v);
    check("R7 second node addr", v, ID_EXP);
    rd1(7'd0, 8'h00, v);
    check("R8 end of chain", v, 8'h00);
    rd1(7'd1, 8'h03, v);
    check("R8 ctrl readback", v, 8'h01);
    rd1(7'd2, 8'h02, v);
    check("R7 node addr readback", v, 8'h02);
  endtask

  task automatic t_info;
    logic [7:0] v;
    rd1(7'd2, 8'h01, v);
    check("R6 info", v, INFO_EXP);
    wr1(7'd2, 8'h01, 8'hFF);
    wr1(7'd2, 8'h00, 8'h00);
    rd1(7'd2, 8'h01, v);
    check("R6 info read-only", v, INFO_EXP);
    rd1(7'd2, 8'h00, v);
    check("R6 ident read-only", v, ID_EXP);
  endtask

  task automatic t_burst;
    wbuf[0] = 8'h80; wbuf[1] = 8'h01; wbuf[2] = 8'hE7; wbuf[3] = 8'h3C;
    xfer(1'b0, 7'd2, 8'h04, 4);
    xfer(1'b1, 7'd2, 8'h04, 4);
    check("R4 R5 burst b0", rbuf[0], 8'h80);
    check("R5 burst b1", rbuf[1], 8'h01);
    check("R5 burst b2", rbuf[2], 8'hE7);
    check("R5 burst b3", rbuf[3], 8'h3C);
    xfer(1'b1, 7'd1, 8'h04, 2);
    check("R2 other node untouched", rbuf[0], 8'h00);
    check("R2 other node untouched", rbuf[1], 8'h00);
  endtask

  task automatic t_bcast;
    logic [7:0] v;
    wr1(7'h7F, 8'h05, 8'hA9);
    rd1(7'd1, 8'h05, v);
    check("R9 bcast node1", v, 8'hA9);
    rd1(7'd2, 8'h05, v);
    check("R9 bcast node2", v, 8'hA9);
    dn_miso = 1'b1;
    rd1(7'h7F, 8'h05, v);
    check("R9 bcast read silent", v, 8'hFF);
    rd1(7'd9, 8'h00, v);
    check("R10 absent device", v, 8'hFF);
    rd1(7'd1, 8'h00, v);
    check("R3 dummy byte", dummy_q, 8'hFF);
    check("R3 data after dummy", v, ID_EXP);
    dn_miso = 1'b0;
  endtask

  task automatic t_abort;
    logic [7:0] v, r;
    csn = 1'b0; wait_clk(HALF);
    xbyte({1'b0, 7'd1}, r);
    pbits(8'h06, 4);
    wait_clk(HALF); csn = 1'b1; wait_clk(4 * HALF);
    csn = 1'b0; wait_clk(HALF);
    xbyte({1'b0, 7'd1}, r);
    xbyte(8'h07, r);
    pbits(8'hFF, 5);
    wait_clk(HALF); csn = 1'b1; wait_clk(4 * HALF);
    rd1(7'd1, 8'h07, v);
    check("R12 partial data dropped", v, 8'h00);
    wr1(7'd1, 8'h06, 8'h5A);
    rd1(7'd1, 8'h06, v);
    check("R12 fresh header after abort", v, 8'h5A);
  endtask

  task automatic t_irq;
    for (int k = 0; k < 8; k++) begin
      {irq0, irq1, irq_end} = 3'(k);
      wait_clk(1);
      check("R11 irq merge", {7'd0, irq_top}, {7'd0, (k != 0)});
    end
    {irq0, irq1, irq_end} = 3'b000;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_passthru();
    t_enumerate();
    t_info();
    t_burst();
    t_bcast();
    t_abort();
    t_irq();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule